// File: doc/BRIEF.md
# Indexed Colour Palette Lookup with Forced-Colour Override

This block turns a stream of 8-bit pixel indices into 24-bit RGB pixels. Each index selects one of 256 palette entries, and each entry holds a 16-bit 5-6-5 colour (red in bits 15:11, green in bits 10:5, blue in bits 4:0). The block widens every channel to 8 bits by repeating its top bits in the spare low bits. A pixel presented with its valid flag comes out one clock later with its valid flag.

A small register bus gives software read and write access to every palette entry and to one override register. When the override is enabled, every output pixel is replaced by a single 24-bit colour, whatever the palette holds. Writing zero as that colour blanks the display.

The palette RAM has one port for the display and one for the CPU. A CPU palette write is stored only on a cycle when the display is not reading; on a busy cycle it is dropped. Software therefore reads each entry back to confirm its write, and repeats any write that failed during vertical blanking, when the display reads nothing.

Top module: `pal_lookup`

## Requirements
- R1: After reset, `pix_valid_o` is 0, `pix_rgb_o` is 0, `bus_rvalid_o` is 0, and the override register reads as all zeros, so the override is disabled.
- R2: `pix_valid_o` is 1 exactly one clock after a cycle in which both `pix_valid_i` and `video_en_i` are 1, and 0 after any other cycle.
- R3: A looked-up pixel comes out as {R8,G8,B8} in bits 23:16, 15:8 and 7:0. The values are R8 = {e[15:11], e[15:13]}, G8 = {e[10:5], e[10:9]} and B8 = {e[4:0], e[4:2]}, where e is the palette entry addressed by the index.
- R4: The override register holds an enable in bit 24 and a colour in bits 23:0 of the bus data. While the enable is 1, every output pixel equals that colour. A colour of 0 gives a blank output.
- R5: While the override enable is 0, output pixels come from the palette as in R3.
- R6: A palette write is stored only if, in the same cycle, `pix_valid_i` and `video_en_i` are not both 1. Otherwise the write is discarded and the entry keeps its old value.
- R7: A bus read (`bus_sel_i`=1, `bus_wr_i`=0) sets `bus_rvalid_o` to 1 one clock later, with the data in `bus_rdata_o`. In all other cycles `bus_rvalid_o` is 0. A palette read returns the stored 16-bit entry in bits 15:0, with zeros above.
- R8: A bus address with bit 8 set selects the override register. Reading it returns the enable in bit 24, the colour in bits 23:0 and zeros above. Addresses 0 to 255, with bit 8 clear, select the palette entries.
- R9: After a cycle with no display read, `pix_rgb_o` keeps its previous value.
- R10: A palette write stores only bus data bits 15:0. Bits 31:16 are ignored, and readback shows them as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| video_en_i | input | 1 | Video output is enabled |
| pix_valid_i | input | 1 | Pixel index is valid in this cycle |
| pix_idx_i | input | 8 | Pixel palette index |
| bus_sel_i | input | 1 | Bus access in this cycle |
| bus_wr_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | 9 | Bit 8 selects the override register; bits 7:0 give the palette entry |
| bus_wdata_i | input | 32 | Write data |
| bus_rvalid_o | output | 1 | Read data is valid |
| bus_rdata_o | output | 32 | Read data |
| pix_valid_o | output | 1 | Output pixel is valid |
| pix_rgb_o | output | 24 | Output pixel, 8 bits per channel |

## Verification
The bench builds the block with its default parameters: an 8-bit index, which gives all 256 palette entries, and a 32-bit bus. With these values it reaches both index extremes, 0 and 255. It also reaches the address bit that moves from the palette to the override register, and the junk upper data bits that R10 requires the block to ignore. Palette writes are placed on display-busy cycles and on idle cycles, the idle cases covering both a gap in valid pixels and video disabled. This shows the dropped write and the committed write side by side through readback.

// File: rtl/pal_lookup_pkg.sv
package pal_lookup_pkg;
  localparam int ENTRY_W    = 16;
  localparam int RGB_W      = 24;
  localparam int OVR_W      = 25;
  localparam int OVR_EN_BIT = 24;

  // widen a 5-bit channel to 8 bits by repeating its top bits
  function automatic logic [7:0] widen5(input logic [4:0] c);
    return {c, c[4:2]};
  endfunction

  // widen a 6-bit channel to 8 bits by repeating its top bits
  function automatic logic [7:0] widen6(input logic [5:0] c);
    return {c, c[5:4]};
  endfunction

  // 5-6-5 entry to 8-8-8 pixel
  function automatic logic [RGB_W-1:0] expand_565(input logic [ENTRY_W-1:0] e);
    return {widen5(e[15:11]), widen6(e[10:5]), widen5(e[4:0])};
  endfunction
endpackage

// File: rtl/pal_ram.sv
module pal_ram #(
  parameter int IDX_W = 8
) (
  input  logic                                clk,
  input  logic                                wr_en,
  input  logic [IDX_W-1:0]                    wr_idx,
  input  logic [pal_lookup_pkg::ENTRY_W-1:0]  wr_data,
  input  logic                                disp_rd,
  input  logic [IDX_W-1:0]                    disp_idx,
  output logic [pal_lookup_pkg::ENTRY_W-1:0]  disp_q,
  input  logic                                cpu_rd,
  input  logic [IDX_W-1:0]                    cpu_idx,
  output logic [pal_lookup_pkg::ENTRY_W-1:0]  cpu_q
);
  localparam int DEPTH = 1 << IDX_W;

  logic [pal_lookup_pkg::ENTRY_W-1:0] mem [DEPTH];

  // CPU port: write, or registered read that returns the value before any same-cycle write
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    if (cpu_rd) cpu_q <= mem[cpu_idx];
  end

  // display port: registered read, holds between reads
  always_ff @(posedge clk) begin
    if (disp_rd) disp_q <= mem[disp_idx];
  end
endmodule

// File: rtl/pal_bus_decode.sv
module pal_bus_decode (
  input  logic bus_sel,
  input  logic bus_wr,
  input  logic sel_ovr,
  input  logic disp_busy,
  output logic pal_wr_commit,
  output logic pal_wr_drop,
  output logic pal_rd,
  output logic ovr_wr,
  output logic ovr_rd
);
  logic wr_req, rd_req;

  always_comb begin
    wr_req        = bus_sel & bus_wr;
    rd_req        = bus_sel & ~bus_wr;
    ovr_wr        = wr_req & sel_ovr;
    ovr_rd        = rd_req & sel_ovr;
    pal_rd        = rd_req & ~sel_ovr;
    pal_wr_commit = wr_req & ~sel_ovr & ~disp_busy;
    pal_wr_drop   = wr_req & ~sel_ovr & disp_busy;
  end
endmodule

// File: rtl/pal_override_reg.sv
module pal_override_reg (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr,
  input  logic [pal_lookup_pkg::OVR_W-1:0]   wdata,
  output logic                               ovr_en,
  output logic [pal_lookup_pkg::RGB_W-1:0]   ovr_col
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovr_en  <= 1'b0;
      ovr_col <= '0;
    end else if (wr) begin
      ovr_en  <= wdata[pal_lookup_pkg::OVR_EN_BIT];
      ovr_col <= wdata[pal_lookup_pkg::RGB_W-1:0];
    end
  end
endmodule

// File: rtl/pal_out_stage.sv
module pal_out_stage (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               disp_rd,
  input  logic                               ovr_en,
  input  logic [pal_lookup_pkg::RGB_W-1:0]   ovr_col,
  input  logic [pal_lookup_pkg::ENTRY_W-1:0] ram_q,
  output logic                               pix_valid_o,
  output logic [pal_lookup_pkg::RGB_W-1:0]   pix_rgb_o
);
  logic                             valid_q;
  logic                             use_ovr_q;
  logic [pal_lookup_pkg::RGB_W-1:0] col_q;

  // reset selects the captured colour, which is zero: output starts black
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      use_ovr_q <= 1'b1;
      col_q     <= '0;
    end else begin
      valid_q <= disp_rd;
      if (disp_rd) begin
        use_ovr_q <= ovr_en;
        col_q     <= ovr_col;
      end
    end
  end

  assign pix_valid_o = valid_q;
  assign pix_rgb_o   = use_ovr_q ? col_q : pal_lookup_pkg::expand_565(ram_q);
endmodule

// File: rtl/pal_lookup.sv
module pal_lookup #(
  parameter int IDX_W = 8,
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             video_en_i,
  input  logic             pix_valid_i,
  input  logic [IDX_W-1:0] pix_idx_i,
  input  logic             bus_sel_i,
  input  logic             bus_wr_i,
  input  logic [IDX_W:0]   bus_addr_i,
  input  logic [BUS_W-1:0] bus_wdata_i,
  output logic             bus_rvalid_o,
  output logic [BUS_W-1:0] bus_rdata_o,
  output logic             pix_valid_o,
  output logic [23:0]      pix_rgb_o
);
  import pal_lookup_pkg::*;

  localparam int ADDR_W = IDX_W + 1;

  logic                disp_rd;
  logic                pal_wr_commit, pal_wr_drop, pal_rd, ovr_wr, ovr_rd;
  logic                ovr_en;
  logic [RGB_W-1:0]    ovr_col;
  logic [ENTRY_W-1:0]  disp_q, cpu_q;
  logic                rvalid_q, rsel_ovr_q;
  logic [OVR_W-1:0]    ovr_snap_q;
  logic                unused_wdata_hi;

  assign disp_rd         = pix_valid_i & video_en_i;
  assign unused_wdata_hi = ^bus_wdata_i[BUS_W-1:OVR_W];

  pal_bus_decode u_dec (
    .bus_sel       (bus_sel_i),
    .bus_wr        (bus_wr_i),
    .sel_ovr       (bus_addr_i[ADDR_W-1]),
    .disp_busy     (disp_rd),
    .pal_wr_commit (pal_wr_commit),
    .pal_wr_drop   (pal_wr_drop),
    .pal_rd        (pal_rd),
    .ovr_wr        (ovr_wr),
    .ovr_rd        (ovr_rd)
  );

  pal_ram #(.IDX_W(IDX_W)) u_ram (
    .clk      (clk),
    .wr_en    (pal_wr_commit),
    .wr_idx   (bus_addr_i[IDX_W-1:0]),
    .wr_data  (bus_wdata_i[ENTRY_W-1:0]),
    .disp_rd  (disp_rd),
    .disp_idx (pix_idx_i),
    .disp_q   (disp_q),
    .cpu_rd   (pal_rd),
    .cpu_idx  (bus_addr_i[IDX_W-1:0]),
    .cpu_q    (cpu_q)
  );

  pal_override_reg u_ovr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (ovr_wr),
    .wdata   (bus_wdata_i[OVR_W-1:0]),
    .ovr_en  (ovr_en),
    .ovr_col (ovr_col)
  );

  pal_out_stage u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .disp_rd     (disp_rd),
    .ovr_en      (ovr_en),
    .ovr_col     (ovr_col),
    .ram_q       (disp_q),
    .pix_valid_o (pix_valid_o),
    .pix_rgb_o   (pix_rgb_o)
  );

  // read return path: one cycle, override value snapshotted at the request
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q   <= 1'b0;
      rsel_ovr_q <= 1'b1;
      ovr_snap_q <= '0;
    end else begin
      rvalid_q <= pal_rd | ovr_rd;
      if (pal_rd | ovr_rd) rsel_ovr_q <= ovr_rd;
      if (ovr_rd) ovr_snap_q <= {ovr_en, ovr_col};
    end
  end

  assign bus_rvalid_o = rvalid_q;
  assign bus_rdata_o  = rsel_ovr_q ? BUS_W'(ovr_snap_q) : BUS_W'(cpu_q);
endmodule

// File: rtl/pal_lookup_chk.sv
module pal_lookup_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        video_en_i,
  input logic        pix_valid_i,
  input logic        bus_sel_i,
  input logic        bus_wr_i,
  input logic        bus_rvalid_o,
  input logic        pix_valid_o,
  input logic [23:0] pix_rgb_o,
  input logic        ovr_en,
  input logic [23:0] ovr_col,
  input logic        pal_wr_commit,
  input logic        pal_wr_drop
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_i && video_en_i) |=> pix_valid_o); // R2
  AST_VALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_valid_i && video_en_i) |=> !pix_valid_o); // R2
  AST_PIXEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_valid_i && video_en_i) |=> $stable(pix_rgb_o)); // R9
  AST_FORCED_COLOUR: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_i && video_en_i && ovr_en) |=> (pix_rgb_o == $past(ovr_col))); // R4
  AST_NO_COMMIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    pal_wr_commit |-> !(pix_valid_i && video_en_i)); // R6
  AST_DROP_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    pal_wr_drop |-> (pix_valid_i && video_en_i && bus_sel_i && bus_wr_i)); // R6
  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel_i && !bus_wr_i) |=> bus_rvalid_o); // R7
  AST_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel_i && !bus_wr_i) |=> !bus_rvalid_o); // R7
endmodule

bind pal_lookup pal_lookup_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .video_en_i    (video_en_i),
  .pix_valid_i   (pix_valid_i),
  .bus_sel_i     (bus_sel_i),
  .bus_wr_i      (bus_wr_i),
  .bus_rvalid_o  (bus_rvalid_o),
  .pix_valid_o   (pix_valid_o),
  .pix_rgb_o     (pix_rgb_o),
  .ovr_en        (ovr_en),
  .ovr_col       (ovr_col),
  .pal_wr_commit (pal_wr_commit),
  .pal_wr_drop   (pal_wr_drop)
);

// File: tb/pal_lookup_tb_top.sv
`timescale 1ns/1ps
module pal_lookup_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        video_en_i = 1'b0;
  logic        pix_valid_i = 1'b0;
  logic [7:0]  pix_idx_i = '0;
  logic        bus_sel_i = 1'b0;
  logic        bus_wr_i = 1'b0;
  logic [8:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic        bus_rvalid_o;
  logic [31:0] bus_rdata_o;
  logic        pix_valid_o;
  logic [23:0] pix_rgb_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pal_lookup dut_i (
    .clk(clk), .rst_n(rst_n), .video_en_i(video_en_i), .pix_valid_i(pix_valid_i),
    .pix_idx_i(pix_idx_i), .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rvalid_o(bus_rvalid_o),
    .bus_rdata_o(bus_rdata_o), .pix_valid_o(pix_valid_o), .pix_rgb_o(pix_rgb_o)
  );

  // reference state
  int          pal_m [256];
  bit          m_ovr_en = 0;
  int          m_ovr_col = 0;
  bit          m_valid = 0;
  int          m_rgb = 0;
  bit          m_rvalid = 0;
  int          m_rdata = 0;

  function automatic int ref_expand(input int v);
    int r, g, b;
    r = (v / 2048) % 32;
    g = (v / 32) % 64;
    b = v % 32;
    return ((r * 8 + r / 4) * 65536) + ((g * 4 + g / 16) * 256) + (b * 8 + b / 4);
  endfunction

  function automatic int pat(input int i);
    return (i * 331 + 4660) % 65536;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural model, advanced on each rising edge from pre-edge inputs
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ovr_en = 0; m_ovr_col = 0; m_valid = 0; m_rgb = 0; m_rvalid = 0;
    end else begin
      bit busy;
      busy = pix_valid_i && video_en_i;
      m_valid = busy;
      if (busy) m_rgb = m_ovr_en ? m_ovr_col : ref_expand(pal_m[pix_idx_i]);
      m_rvalid = bus_sel_i && !bus_wr_i;
      if (m_rvalid)
        m_rdata = bus_addr_i[8] ? (int'(m_ovr_en) * 16777216 + m_ovr_col) : pal_m[bus_addr_i[7:0]];
      if (bus_sel_i && bus_wr_i) begin
        if (bus_addr_i[8]) begin
          m_ovr_en  = bus_wdata_i[24];
          m_ovr_col = int'(bus_wdata_i[23:0]);
        end else if (!busy) begin
          pal_m[bus_addr_i[7:0]] = int'(bus_wdata_i[15:0]);
        end
      end
    end
  end

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 pix_valid_o", pix_valid_o, m_valid);
      chk("R3 R4 R5 R9 pix_rgb_o", pix_rgb_o, m_rgb);
      chk("R7 bus_rvalid_o", bus_rvalid_o, m_rvalid);
      if (m_rvalid) chk("R7 R8 bus_rdata_o", bus_rdata_o, m_rdata);
    end
  end

  task automatic bus_write(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel_i = 1; bus_wr_i = 1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_sel_i = 0; bus_wr_i = 0;
  endtask

  task automatic bus_read(input logic [8:0] a, output logic [31:0] q);
    @(negedge clk);
    bus_sel_i = 1; bus_wr_i = 0; bus_addr_i = a;
    @(negedge clk);
    bus_sel_i = 0;
    q = bus_rdata_o;
  endtask

  task automatic stream(input int n, input int mode);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      pix_valid_i = (mode == 2) ? (k % 3 != 0) : 1'b1;
      case (mode)
        0: pix_idx_i = 8'(k % 256);
        1: pix_idx_i = (k % 2 == 1) ? 8'd255 : 8'd0;
        default: pix_idx_i = 8'((k * 37 + 5) % 256);
      endcase
    end
    @(negedge clk);
    pix_valid_i = 0;
  endtask

  task automatic one_pixel(input logic [7:0] idx, output logic [23:0] rgb);
    @(negedge clk);
    pix_valid_i = 1; pix_idx_i = idx;
    @(negedge clk);
    pix_valid_i = 0;
    rgb = pix_rgb_o;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired before all R checks finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] q;
    logic [23:0] px;
    for (int i = 0; i < 256; i++) pal_m[i] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pix_valid_o", pix_valid_o, 0);
    chk("R1 pix_rgb_o", pix_rgb_o, 0);
    chk("R1 bus_rvalid_o", bus_rvalid_o, 0);
    bus_read(9'h100, q);
    chk("R1 override after reset", q, 0);

    // load palette with video off; junk in upper data bits (R10)
    for (int i = 0; i < 256; i++) bus_write(9'(i), 32'hABCD0000 | 32'(pat(i)));
    bus_read(9'd0, q);   chk("R7 R10 entry 0", q, pat(0));
    bus_read(9'd7, q);   chk("R7 R10 entry 7", q, pat(7));
    bus_read(9'd255, q); chk("R7 R10 entry 255", q, pat(255));

    // lookups under several patterns (R2 R3 R9)
    @(negedge clk); video_en_i = 1;
    stream(300, 0);
    stream(40, 1);
    stream(90, 2);
    one_pixel(8'd255, px);
    chk("R3 expand entry 255", px, ref_expand(pat(255)));
    repeat (3) @(negedge clk);
    chk("R9 held after idle", pix_rgb_o, ref_expand(pat(255)));

    // override blanking and forced colour (R4 R8)
    bus_write(9'h100, 32'h0100_0000);
    stream(20, 0);
    one_pixel(8'd9, px);
    chk("R4 blank colour", px, 0);
    bus_write(9'h100, 32'hFE12_3456 | 32'h0100_0000);
    stream(20, 2);
    one_pixel(8'd3, px);
    chk("R4 forced colour", px, 24'h123456);
    bus_read(9'h100, q);
    chk("R8 override readback", q, 32'h0112_3456);
    bus_read(9'h1FF, q);
    chk("R8 override alias", q, 32'h0112_3456);

    // override off, palette again (R5)
    bus_write(9'h100, 32'h00AB_CDEF);
    one_pixel(8'd7, px);
    chk("R5 palette after override off", px, ref_expand(pat(7)));
    stream(30, 1);

    // write collision (R6)
    @(negedge clk); pix_valid_i = 1; pix_idx_i = 8'd3;
    bus_sel_i = 1; bus_wr_i = 1; bus_addr_i = 9'd10; bus_wdata_i = 32'h0000_BEEF;
    @(negedge clk); bus_sel_i = 0; bus_wr_i = 0; pix_valid_i = 0;
    bus_read(9'd10, q);
    chk("R6 busy write dropped", q, pat(10));
    bus_write(9'd10, 32'h0000_BEEF);
    bus_read(9'd10, q);
    chk("R6 gap write committed", q, 32'h0000_BEEF);
    @(negedge clk); video_en_i = 0; pix_valid_i = 1;
    bus_sel_i = 1; bus_wr_i = 1; bus_addr_i = 9'd11; bus_wdata_i = 32'h0000_F00D;
    @(negedge clk); bus_sel_i = 0; bus_wr_i = 0; pix_valid_i = 0;
    bus_read(9'd11, q);
    chk("R6 video-off write committed", q, 32'h0000_F00D);
    @(negedge clk); video_en_i = 1;
    one_pixel(8'd10, px);
    chk("R3 R6 new entry displayed", px, ref_expand(32'h0000_BEEF));
    stream(50, 0);

    repeat (4) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule